// File: doc/BRIEF.md
# Memoryless Interrupt Entry Controller

This block is the control path a processor core uses to enter and leave an interrupt or fault handler without any load or store. When a request is accepted, the block captures the interrupted program counter and the live status word into dedicated special registers. It records the number of the accepted cause, switches the status word into handler form with address translation and interrupt acceptance turned off, and steers instruction fetch to a slot computed from a vector-base register. Nothing in this sequence touches memory. Handler software saves and restores general registers itself, because none are banked.

Requests come in as one line per cause. The lowest-numbered lines are faults and are never masked. The remaining lines are interrupts, accepted only while the interrupt-enable bit of the status word is set and the core is outside the handler. A return strobe puts back the saved status and sends fetch to the saved program counter in one step. A fault raised while the handler is running cannot be serviced, so the block freezes in a locked state that only reset leaves. An optional reboot enable turns that locked state into a reset request toward the system.

The controller has three states. RUN is normal execution. HANDLER is service mode. LOCKED is the frozen state after a nested fault. Its transitions are: *enter* (RUN to HANDLER, on an accepted request), *return* (HANDLER to RUN, on the return strobe), *nested fault* (HANDLER to LOCKED, on any fault request), and *reset* (any state to RUN, on `rst_n` low).

Top module: `irq_entry_ctrl`

## Requirements
- R1: While `rst_n` is low and in the first cycle after it rises, the block is in RUN. `sr_o`, `epc_o`, `ssr_o` and `cause_o` are zero, `handler_o`, `locked_o`, `reset_req_o` and `redirect_o` are low, and the vector base holds `VBR_RESET`.
- R2: In RUN, cause lines 0 to `NUM_FAULT-1` are faults and are always eligible. Higher lines are interrupts and are eligible only when status bit 1 (interrupt enable) is set. Among the eligible lines, the lowest index is accepted.
- R3: One cycle after an accept, `epc_o` holds the `cur_pc_i` value from the accepting cycle, `ssr_o` holds the status word from before the accept, and `cause_o` holds the accepted index. All three stay unchanged for as long as the block is in HANDLER.
- R4: One cycle after an accept, `handler_o` is high and `sr_o` has bit 0 (translation enable) and bit 1 (interrupt enable) cleared. All other status bits keep their values.
- R5: One cycle after an accept, `redirect_o` is high for exactly one cycle and `redirect_pc_o` equals the vector base + index × 2^`SLOT_SHIFT` (16-byte slots by default). The vector base used is the value held before that cycle.
- R6: In HANDLER, interrupt lines have no effect on any output.
- R7: A return strobe in HANDLER with no fault request restores `sr_o` from `ssr_o`, lowers `handler_o`, and one cycle later pulses `redirect_o` with `redirect_pc_o` equal to `epc_o`. A return strobe in RUN has no effect.
- R8: Any fault line raised in HANDLER moves the block to LOCKED on the next edge, even if the return strobe is also high. `epc_o`, `ssr_o`, `cause_o` and `sr_o` keep their values.
- R9: In LOCKED, `locked_o` and `handler_o` stay high. Requests, return strobes and status writes have no effect. Only reset leaves the state.
- R10: `reset_req_o` is high exactly when the block is in LOCKED and `reboot_en_i` is high.
- R11: A status write (`sr_we_i`) or vector-base write (`vbr_we_i`) takes effect on the next edge. A status write is dropped when an accept, return or nested fault happens in the same cycle, and it is dropped in LOCKED.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | NUM_CAUSE | One request line per cause; low indices are faults |
| cur_pc_i | input | PC_W | Program counter of the instruction being interrupted |
| rti_i | input | 1 | Return-from-handler strobe |
| sr_we_i | input | 1 | Status word write enable |
| sr_wdata_i | input | SR_W | Status word write data |
| vbr_we_i | input | 1 | Vector base write enable |
| vbr_wdata_i | input | PC_W | Vector base write data |
| reboot_en_i | input | 1 | Turns LOCKED into a reset request |
| sr_o | output | SR_W | Live status word (bit 0 translation enable, bit 1 interrupt enable) |
| epc_o | output | PC_W | Saved return program counter |
| ssr_o | output | SR_W | Saved status word |
| cause_o | output | CAUSE_W | Index of the last accepted cause |
| handler_o | output | 1 | High in HANDLER and LOCKED |
| locked_o | output | 1 | High in LOCKED |
| reset_req_o | output | 1 | Reset request to the system |
| redirect_o | output | 1 | One-cycle fetch redirect strobe |
| redirect_pc_o | output | PC_W | Fetch target, valid while `redirect_o` is high |

## Verification
Every result of an accept, return or nested fault is registered. It is therefore due exactly one edge after the cycle whose inputs caused it. The only exception is `reset_req_o`, which follows `reboot_en_i` within the same cycle once the block is locked. The bench drives inputs just after the falling edge, so they are stable at the next rising edge. Its behavioural model updates on that same rising edge, and every output is compared with the model at the following falling edge. Each result is therefore examined in the cycle it is due and never earlier. At chosen points, explicit checks against literal target addresses, saved values and state flags confirm the model itself.

// File: rtl/irqe_pkg.sv
package irqe_pkg;

    typedef enum logic [1:0] {
        ST_RUN     = 2'd0,
        ST_HANDLER = 2'd1,
        ST_LOCKED  = 2'd2
    } irqe_state_e;

    // status word bit positions decoded by the rest of the core
    localparam int SR_XLATE_BIT = 0;
    localparam int SR_IRQEN_BIT = 1;

endpackage

// File: rtl/irqe_pick.sv
module irqe_pick #(
    parameter int NUM_CAUSE = 8,
    parameter int NUM_FAULT = 2,
    parameter int CAUSE_W   = 3
) (
    input  logic [NUM_CAUSE-1:0] req_i,
    input  logic                 irq_allowed_i,
    output logic                 hit_o,
    output logic [CAUSE_W-1:0]   idx_o,
    output logic                 fault_any_o
);

    logic [NUM_CAUSE-1:0] eligible;
    logic [NUM_CAUSE-1:0] fault_lines;

    for (genvar g = 0; g < NUM_CAUSE; g++) begin : g_line
        if (g < NUM_FAULT) begin : g_fault
            assign eligible[g]    = req_i[g];
            assign fault_lines[g] = req_i[g];
        end else begin : g_irq
            assign eligible[g]    = req_i[g] & irq_allowed_i;
            assign fault_lines[g] = 1'b0;
        end
    end

    // lowest index wins: scan from the top so the last match is the lowest
    always_comb begin
        idx_o = '0;
        for (int i = NUM_CAUSE - 1; i >= 0; i--) begin
            if (eligible[i]) begin
                idx_o = CAUSE_W'(i);
            end
        end
    end

    assign hit_o       = |eligible;
    assign fault_any_o = |fault_lines;

endmodule

// File: rtl/irqe_fsm.sv
module irqe_fsm
    import irqe_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        hit_i,
    input  logic        fault_any_i,
    input  logic        rti_i,
    output irqe_state_e state_o,
    output logic        take_o,
    output logic        ret_o,
    output logic        lock_go_o,
    output logic        handler_o,
    output logic        locked_o
);

    irqe_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_RUN;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN: begin
                if (hit_i) state_d = ST_HANDLER;             // enter
            end
            ST_HANDLER: begin
                if (fault_any_i)  state_d = ST_LOCKED;       // nested fault
                else if (rti_i)   state_d = ST_RUN;          // return
            end
            ST_LOCKED: begin
                state_d = ST_LOCKED;                         // only reset leaves
            end
            default: state_d = ST_RUN;
        endcase
    end

    always_comb begin
        take_o    = 1'b0;
        ret_o     = 1'b0;
        lock_go_o = 1'b0;
        handler_o = 1'b0;
        locked_o  = 1'b0;
        unique case (state_q)
            ST_RUN: begin
                take_o = hit_i;
            end
            ST_HANDLER: begin
                handler_o = 1'b1;
                lock_go_o = fault_any_i;
                ret_o     = rti_i & ~fault_any_i;
            end
            ST_LOCKED: begin
                handler_o = 1'b1;
                locked_o  = 1'b1;
            end
            default: ;
        endcase
    end

    assign state_o = state_q;

    AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == ST_LOCKED |=> state_q == ST_LOCKED); // R9

    AST_LOCK_ONLY_FROM_HANDLER: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN) |=> state_q != ST_LOCKED); // R8

    AST_ONE_ACTION: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({take_o, ret_o, lock_go_o}) <= 1); // R7

endmodule

// File: rtl/irqe_sregs.sv
module irqe_sregs
    import irqe_pkg::*;
#(
    parameter int              PC_W       = 32,
    parameter int              SR_W       = 4,
    parameter int              CAUSE_W    = 3,
    parameter int              SLOT_SHIFT = 4,
    parameter logic [PC_W-1:0] VBR_RESET  = '0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               take_i,
    input  logic               ret_i,
    input  logic               lock_go_i,
    input  logic               locked_i,
    input  logic               handler_i,
    input  logic [CAUSE_W-1:0] take_idx_i,
    input  logic [PC_W-1:0]    cur_pc_i,
    input  logic               sr_we_i,
    input  logic [SR_W-1:0]    sr_wdata_i,
    input  logic               vbr_we_i,
    input  logic [PC_W-1:0]    vbr_wdata_i,
    output logic [SR_W-1:0]    sr_o,
    output logic [PC_W-1:0]    epc_o,
    output logic [SR_W-1:0]    ssr_o,
    output logic [CAUSE_W-1:0] cause_o,
    output logic               redirect_o,
    output logic [PC_W-1:0]    redirect_pc_o
);

    localparam logic [SR_W-1:0] ENTRY_CLEAR =
        SR_W'((1 << SR_XLATE_BIT) | (1 << SR_IRQEN_BIT));

    logic [SR_W-1:0]    sr_q, ssr_q;
    logic [PC_W-1:0]    epc_q, vbr_q, rpc_q;
    logic [CAUSE_W-1:0] cause_q;
    logic               redir_q;
    logic [PC_W-1:0]    slot_target;

    assign slot_target = vbr_q + (PC_W'(take_idx_i) << SLOT_SHIFT);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sr_q <= '0;
        end else if (take_i) begin
            sr_q <= sr_q & ~ENTRY_CLEAR;
        end else if (ret_i) begin
            sr_q <= ssr_q;
        end else if (sr_we_i && !locked_i && !lock_go_i) begin
            sr_q <= sr_wdata_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            epc_q   <= '0;
            ssr_q   <= '0;
            cause_q <= '0;
        end else if (take_i) begin
            epc_q   <= cur_pc_i;
            ssr_q   <= sr_q;
            cause_q <= take_idx_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vbr_q <= VBR_RESET;
        end else if (vbr_we_i) begin
            vbr_q <= vbr_wdata_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            redir_q <= 1'b0;
            rpc_q   <= '0;
        end else begin
            redir_q <= take_i | ret_i;
            if (take_i) begin
                rpc_q <= slot_target;
            end else if (ret_i) begin
                rpc_q <= epc_q;
            end
        end
    end

    assign sr_o          = sr_q;
    assign epc_o         = epc_q;
    assign ssr_o         = ssr_q;
    assign cause_o       = cause_q;
    assign redirect_o    = redir_q;
    assign redirect_pc_o = rpc_q;

    AST_ENTRY_MASKS: assert property (@(posedge clk) disable iff (!rst_n)
        take_i |=> !sr_q[SR_XLATE_BIT] && !sr_q[SR_IRQEN_BIT]); // R4

    AST_EPC_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        handler_i && !take_i |=> $stable(epc_q) && $stable(ssr_q)); // R3

    AST_RETURN_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
        ret_i |=> redir_q && rpc_q == $past(epc_q)); // R7

    AST_LOCK_FREEZES_SR: assert property (@(posedge clk) disable iff (!rst_n)
        (locked_i || lock_go_i) |=> $stable(sr_q)); // R8

endmodule

// File: rtl/irq_entry_ctrl.sv
module irq_entry_ctrl
    import irqe_pkg::*;
#(
    parameter int              PC_W       = 32,
    parameter int              SR_W       = 4,
    parameter int              NUM_CAUSE  = 8,
    parameter int              NUM_FAULT  = 2,
    parameter int              SLOT_SHIFT = 4,
    parameter logic [PC_W-1:0] VBR_RESET  = '0,
    localparam int             CAUSE_W    = (NUM_CAUSE > 1) ? $clog2(NUM_CAUSE) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_CAUSE-1:0] req_i,
    input  logic [PC_W-1:0]      cur_pc_i,
    input  logic                 rti_i,
    input  logic                 sr_we_i,
    input  logic [SR_W-1:0]      sr_wdata_i,
    input  logic                 vbr_we_i,
    input  logic [PC_W-1:0]      vbr_wdata_i,
    input  logic                 reboot_en_i,
    output logic [SR_W-1:0]      sr_o,
    output logic [PC_W-1:0]      epc_o,
    output logic [SR_W-1:0]      ssr_o,
    output logic [CAUSE_W-1:0]   cause_o,
    output logic                 handler_o,
    output logic                 locked_o,
    output logic                 reset_req_o,
    output logic                 redirect_o,
    output logic [PC_W-1:0]      redirect_pc_o
);

    irqe_state_e        state;
    logic               hit, fault_any, take, ret, lock_go;
    logic [CAUSE_W-1:0] pick_idx;
    logic               irq_allowed;

    assign irq_allowed = (state == ST_RUN) & sr_o[SR_IRQEN_BIT];

    irqe_pick #(
        .NUM_CAUSE (NUM_CAUSE),
        .NUM_FAULT (NUM_FAULT),
        .CAUSE_W   (CAUSE_W)
    ) u_pick (
        .req_i         (req_i),
        .irq_allowed_i (irq_allowed),
        .hit_o         (hit),
        .idx_o         (pick_idx),
        .fault_any_o   (fault_any)
    );

    irqe_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .hit_i       (hit),
        .fault_any_i (fault_any),
        .rti_i       (rti_i),
        .state_o     (state),
        .take_o      (take),
        .ret_o       (ret),
        .lock_go_o   (lock_go),
        .handler_o   (handler_o),
        .locked_o    (locked_o)
    );

    irqe_sregs #(
        .PC_W       (PC_W),
        .SR_W       (SR_W),
        .CAUSE_W    (CAUSE_W),
        .SLOT_SHIFT (SLOT_SHIFT),
        .VBR_RESET  (VBR_RESET)
    ) u_sregs (
        .clk           (clk),
        .rst_n         (rst_n),
        .take_i        (take),
        .ret_i         (ret),
        .lock_go_i     (lock_go),
        .locked_i      (locked_o),
        .handler_i     (handler_o),
        .take_idx_i    (pick_idx),
        .cur_pc_i      (cur_pc_i),
        .sr_we_i       (sr_we_i),
        .sr_wdata_i    (sr_wdata_i),
        .vbr_we_i      (vbr_we_i),
        .vbr_wdata_i   (vbr_wdata_i),
        .sr_o          (sr_o),
        .epc_o         (epc_o),
        .ssr_o         (ssr_o),
        .cause_o       (cause_o),
        .redirect_o    (redirect_o),
        .redirect_pc_o (redirect_pc_o)
    );

    assign reset_req_o = locked_o & reboot_en_i;

    AST_REBOOT_ONLY_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        reset_req_o |-> locked_o); // R10

    AST_SSR_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(handler_o) |-> ssr_o == $past(sr_o)); // R3

    AST_NO_REDIRECT_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        locked_o && $past(locked_o) |-> !redirect_o); // R9

endmodule

// File: tb/irq_entry_ctrl_bench.sv
`timescale 1ns/1ps
module irq_entry_ctrl_bench;

    localparam int PC_W = 32;
    localparam int SR_W = 4;
    localparam int NC   = 8;
    localparam int NF   = 2;
    localparam int CW   = 3;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [NC-1:0]   req = '0;
    logic [PC_W-1:0] cur_pc = '0;
    logic            rti = 1'b0;
    logic            sr_we = 1'b0;
    logic [SR_W-1:0] sr_wd = '0;
    logic            vbr_we = 1'b0;
    logic [PC_W-1:0] vbr_wd = '0;
    logic            reboot_en = 1'b0;

    logic [SR_W-1:0] sr_o, ssr_o;
    logic [PC_W-1:0] epc_o, rpc_o;
    logic [CW-1:0]   cause_o;
    logic            handler_o, locked_o, rreq_o, redir_o;

    always #2 clk = ~clk;

    irq_entry_ctrl u_irq_entry_ctrl (
        .clk(clk), .rst_n(rst_n), .req_i(req), .cur_pc_i(cur_pc), .rti_i(rti),
        .sr_we_i(sr_we), .sr_wdata_i(sr_wd), .vbr_we_i(vbr_we), .vbr_wdata_i(vbr_wd),
        .reboot_en_i(reboot_en), .sr_o(sr_o), .epc_o(epc_o), .ssr_o(ssr_o),
        .cause_o(cause_o), .handler_o(handler_o), .locked_o(locked_o),
        .reset_req_o(rreq_o), .redirect_o(redir_o), .redirect_pc_o(rpc_o)
    );

    // behavioural reference: 0 = run, 1 = handler, 2 = locked
    integer          m_st;
    logic [SR_W-1:0] m_sr, m_ssr;
    logic [PC_W-1:0] m_epc, m_vbr, m_rpc;
    integer          m_cause;
    logic            m_redir;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_st <= 0; m_sr <= '0; m_ssr <= '0; m_epc <= '0; m_vbr <= '0;
            m_cause <= 0; m_redir <= 1'b0; m_rpc <= '0;
        end else begin
            integer pick;
            pick = -1;
            m_redir <= 1'b0;
            if (vbr_we) m_vbr <= vbr_wd;
            if (m_st == 0) begin
                for (int i = NC - 1; i >= 0; i--)
                    if (req[i] && (i < NF || m_sr[1])) pick = i;
                if (pick >= 0) begin
                    m_epc <= cur_pc; m_ssr <= m_sr; m_cause <= pick;
                    m_sr <= m_sr & 4'b1100; m_st <= 1; m_redir <= 1'b1;
                    m_rpc <= m_vbr + PC_W'(pick * 16);
                end else if (sr_we) m_sr <= sr_wd;
            end else if (m_st == 1) begin
                if (req[NF-1:0] != '0) m_st <= 2;
                else if (rti) begin
                    m_sr <= m_ssr; m_redir <= 1'b1; m_rpc <= m_epc; m_st <= 0;
                end else if (sr_we) m_sr <= sr_wd;
            end
        end
    end

    integer n_run = 0;
    integer n_fail = 0;
    string  cur_tag = "R1";
    bit     done = 1'b0;

    task automatic check(input string tag, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s act=%0h exp=%0h", tag, what, act, exp);
        end
    endtask

    task automatic compare_all();
        check(cur_tag, "sr", 64'(sr_o), 64'(m_sr));
        check(cur_tag, "epc", 64'(epc_o), 64'(m_epc));
        check(cur_tag, "ssr", 64'(ssr_o), 64'(m_ssr));
        check(cur_tag, "cause", 64'(cause_o), 64'(m_cause));
        check(cur_tag, "handler", 64'(handler_o), 64'(m_st != 0));
        check(cur_tag, "locked", 64'(locked_o), 64'(m_st == 2));
        check(cur_tag, "reset_req", 64'(rreq_o), 64'(m_st == 2 && reboot_en));
        check(cur_tag, "redirect", 64'(redir_o), 64'(m_redir));
        if (m_redir) check(cur_tag, "redirect_pc", 64'(rpc_o), 64'(m_rpc));
    endtask

    task automatic cyc();
        @(posedge clk);
        @(negedge clk);
        compare_all();
        req = '0; rti = 1'b0; sr_we = 1'b0; vbr_we = 1'b0;
    endtask

    task automatic summary();
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(4 * 20000);
        n_fail++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        // R1: reset state
        cur_tag = "R1";
        rst_n = 1'b0;
        repeat (3) cyc();
        rst_n = 1'b1;
        cyc();
        check("R1", "sr_zero", 64'(sr_o), 64'h0);
        check("R1", "not_handler", 64'(handler_o), 64'h0);

        // R11: program vector base and status
        cur_tag = "R11";
        vbr_we = 1'b1; vbr_wd = 32'h1000;
        sr_we = 1'b1; sr_wd = 4'b1011;
        cyc();
        check("R11", "sr_written", 64'(sr_o), 64'hB);

        // R2 R5: two interrupts together, lowest taken
        cur_tag = "R2";
        req = 8'b0010_1000; cur_pc = 32'h200;
        cyc();
        check("R2", "cause_lowest", 64'(cause_o), 64'd3);
        check("R5", "slot_target", 64'(rpc_o), 64'h1030);
        check("R4", "masks_cleared", 64'(sr_o), 64'h8);
        check("R3", "epc_saved", 64'(epc_o), 64'h200);
        cyc();
        check("R5", "single_pulse", 64'(redir_o), 64'h0);

        // R6: interrupt lines ignored in handler
        cur_tag = "R6";
        req = 8'b0100_0000;
        cyc();
        check("R6", "cause_kept", 64'(cause_o), 64'd3);
        check("R6", "no_redirect", 64'(redir_o), 64'h0);

        // R7: return restores state
        cur_tag = "R7";
        rti = 1'b1;
        cyc();
        check("R7", "sr_restored", 64'(sr_o), 64'hB);
        check("R7", "ret_target", 64'(rpc_o), 64'h200);
        rti = 1'b1;
        cyc();
        check("R7", "rti_in_run_ignored", 64'(redir_o), 64'h0);

        // R2: interrupts masked when enable bit clear, fault still taken
        cur_tag = "R2";
        sr_we = 1'b1; sr_wd = 4'b0001;
        cyc();
        req = 8'b0001_0000;
        cyc();
        check("R2", "masked_irq", 64'(handler_o), 64'h0);
        req = 8'b0001_0010; cur_pc = 32'h344;
        cyc();
        check("R2", "fault_taken", 64'(cause_o), 64'd1);
        check("R5", "fault_slot", 64'(rpc_o), 64'h1010);
        rti = 1'b1;
        cyc();

        // R11: same-cycle status write loses to an accept
        cur_tag = "R11";
        req = 8'b0000_0011; sr_we = 1'b1; sr_wd = 4'b0111; cur_pc = 32'h400;
        cyc();
        check("R11", "write_dropped", 64'(sr_o), 64'h0);
        check("R2", "fault0_first", 64'(cause_o), 64'd0);
        rti = 1'b1;
        cyc();

        // R5: highest slot
        cur_tag = "R5";
        sr_we = 1'b1; sr_wd = 4'b0010;
        cyc();
        vbr_we = 1'b1; vbr_wd = 32'h8000;
        cyc();
        req = 8'b1000_0000; cur_pc = 32'h77C;
        cyc();
        check("R5", "top_slot", 64'(rpc_o), 64'h8070);

        // R8: nested fault beats return
        cur_tag = "R8";
        req = 8'b0000_0001; rti = 1'b1;
        cyc();
        check("R8", "locked", 64'(locked_o), 64'h1);
        check("R8", "epc_kept", 64'(epc_o), 64'h77C);
        check("R8", "cause_kept", 64'(cause_o), 64'd7);

        // R9: locked ignores everything
        cur_tag = "R9";
        rti = 1'b1; req = 8'hFF; sr_we = 1'b1; sr_wd = 4'hF;
        cyc();
        check("R9", "still_locked", 64'(locked_o), 64'h1);
        check("R9", "sr_frozen", 64'(sr_o), 64'h0);

        // R10: reboot request follows enable while locked
        cur_tag = "R10";
        check("R10", "no_req", 64'(rreq_o), 64'h0);
        reboot_en = 1'b1;
        #1;
        check("R10", "req_up", 64'(rreq_o), 64'h1);
        cyc();

        // R1: reset clears the lock
        cur_tag = "R1";
        rst_n = 1'b0;
        cyc();
        rst_n = 1'b1;
        cyc();
        check("R1", "unlocked", 64'(locked_o), 64'h0);
        check("R10", "req_down", 64'(rreq_o), 64'h0);
        reboot_en = 1'b0;
        cyc();
        summary();
    end

endmodule